// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block multiplies two operands of up to 18 bits and folds the product into a running sum. The sum is held in a register that is 16 bits wider than the product, so many products can pile up before the range is exceeded. On every enabled clock edge the new product can be added to the sum or taken away from it, which lets a filter run in decimating form. A load control throws the old sum away and starts a new one from the current product.

Each operand has its own run-time sign-mode input, so the product can be treated as signed by signed, signed by unsigned, or unsigned by unsigned. The sign modes that drive the multiplier pass through 0 or 1 pipeline registers, chosen at build time. The add/subtract control, the load control and the sign modes seen by the accumulator pass through 0, 1 or 2 registers. These depths are set so that the controls meet their data at the accumulator.

The registered operands are also driven out on chain outputs, so that a neighbouring unit can take them. A sticky flag reports overflow, or underflow when subtracting. It is judged in the signed sense when either operand is signed, and as an unsigned carry or borrow otherwise.

Top module: `mac_unit`

## Requirements
- R1: While reset is held low, `acc_out`, `ovf`, `a_chain` and `b_chain` are all zero.
- R2: `a_chain` and `b_chain` show the operands that were present on `a_in` and `b_in` at the previous enabled clock edge.
- R3: The product uses each operand as two's complement when its sign input is 1 and as unsigned when it is 0. With the default depths, operands and controls applied before edge k give a result on `acc_out` after edge k+1. If `load` is 1, `acc_out` becomes the product, extended to the accumulator width, and `ovf` is cleared.
- R4: If `load` is 0 and `sub_mode` is 0, `acc_out` becomes the held sum plus the product, modulo 2^ACC_W.
- R5: If `load` is 0 and `sub_mode` is 1, `acc_out` becomes the held sum minus the product, modulo 2^ACC_W.
- R6: When either sign input is 1, `ovf` is set if the true signed result lies outside the signed range of ACC_W bits.
- R7: When both sign inputs are 0, `ovf` is set on a carry out of an addition or on a borrow in a subtraction.
- R8: Once set, `ovf` stays 1 until a load operation or a reset.
- R9: While `ce` is 0, `acc_out`, `ovf` and the chain outputs hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous clear, active low; internally released on the clock |
| ce | input | 1 | Clock enable for every register |
| a_in | input | A_W | Operand A |
| b_in | input | B_W | Operand B |
| a_signed | input | 1 | 1: operand A is two's complement |
| b_signed | input | 1 | 1: operand B is two's complement |
| sub_mode | input | 1 | 1: subtract the product, 0: add it |
| load | input | 1 | 1: restart the sum from the product |
| acc_out | output | A_W+B_W+GUARD_W | Accumulated sum |
| ovf | output | 1 | Sticky overflow/underflow flag |
| a_chain | output | A_W | Registered operand A for the next unit |
| b_chain | output | B_W | Registered operand B for the next unit |

## Verification
The checker assertions watch, on every cycle, that a disabled clock freezes the sum, the flag and the chain outputs, that the chain outputs follow the operands by one enabled edge, that a load clears the flag, and that a set flag survives every operation that is not a load. Whether the sum and the flag are arithmetically right is something only the bench scenarios can show. A small build is used: every operand pair under all four sign-mode combinations goes through a load, and a long pseudo-random stream mixes adds, subtracts, loads and sign modes. Each result is compared with integer arithmetic, including wrap-around and the two ways of judging overflow.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic sub;
    logic load;
    logic a_sgn;
    logic b_sgn;
  } mac_ctl_t;
  localparam int CTL_W = $bits(mac_ctl_t);
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign arst_n = sync_q[1];
endmodule

// File: rtl/mac_delay.sv
module mac_delay #(
  parameter int W      = 1,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else if (ce) begin
          stg_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  localparam int PROD_W = A_W + B_W
) (
  input  logic [A_W-1:0]    a,
  input  logic [B_W-1:0]    b,
  input  logic              a_sgn,
  input  logic              b_sgn,
  output logic [PROD_W-1:0] prod
);
  logic signed [A_W:0]        a_x;
  logic signed [B_W:0]        b_x;
  logic signed [PROD_W+1:0]   full;

  always_comb begin
    a_x  = {a_sgn & a[A_W-1], a};
    b_x  = {b_sgn & b[B_W-1], b};
    full = a_x * b_x;
    prod = full[PROD_W-1:0];
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int PROD_W  = 36,
  parameter int GUARD_W = 16,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              ce,
  input  logic [PROD_W-1:0] prod,
  input  logic              signed_mode,
  input  logic              sub,
  input  logic              load,
  output logic [ACC_W-1:0]  acc_out,
  output logic              ovf
);
  logic [ACC_W-1:0] acc_q, acc_d, p_ext;
  logic             ovf_q, ovf_d, ovf_now;
  logic [ACC_W:0]   res;
  logic             m_acc, m_p, m_res;

  always_comb begin
    p_ext = {{GUARD_W{signed_mode & prod[PROD_W-1]}}, prod};
    if (sub) res = {1'b0, acc_q} - {1'b0, p_ext};
    else     res = {1'b0, acc_q} + {1'b0, p_ext};
    m_acc = acc_q[ACC_W-1];
    m_p   = p_ext[ACC_W-1];
    m_res = res[ACC_W-1];
    if (signed_mode) ovf_now = (sub ? (m_acc != m_p) : (m_acc == m_p)) && (m_res != m_acc);
    else             ovf_now = res[ACC_W];
    if (load) begin
      acc_d = p_ext;
      ovf_d = 1'b0;
    end else begin
      acc_d = res[ACC_W-1:0];
      ovf_d = ovf_q | ovf_now;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ce) begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_out = acc_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int A_W         = 18,
  parameter int B_W         = 18,
  parameter int GUARD_W     = 16,
  parameter int SIGN_STAGES = 1,
  parameter int CTRL_STAGES = 1,
  localparam int PROD_W     = A_W + B_W,
  localparam int ACC_W      = PROD_W + GUARD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             sub_mode,
  input  logic             load,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf,
  output logic [A_W-1:0]   a_chain,
  output logic [B_W-1:0]   b_chain
);
  logic              arst_n;
  logic [A_W-1:0]    a_q;
  logic [B_W-1:0]    b_q;
  logic [1:0]        sgn_m;
  mac_ctl_t          ctl_in, ctl_d;
  logic [CTL_W-1:0]  ctl_vec;
  logic [PROD_W-1:0] prod;
  logic              ld_eff;

  mac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .arst_n(arst_n));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ce) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  assign ctl_in = '{sub: sub_mode, load: load, a_sgn: a_signed, b_sgn: b_signed};

  mac_delay #(.W(2), .STAGES(SIGN_STAGES)) u_sgn_dly (
    .clk(clk), .arst_n(arst_n), .ce(ce),
    .d({a_signed, b_signed}), .q(sgn_m)
  );

  mac_delay #(.W(CTL_W), .STAGES(CTRL_STAGES)) u_ctl_dly (
    .clk(clk), .arst_n(arst_n), .ce(ce),
    .d(ctl_in), .q(ctl_vec)
  );

  assign ctl_d  = mac_ctl_t'(ctl_vec);
  assign ld_eff = ctl_d.load;

  mac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
    .a(a_q), .b(b_q), .a_sgn(sgn_m[1]), .b_sgn(sgn_m[0]), .prod(prod)
  );

  mac_accum #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_acc (
    .clk(clk), .arst_n(arst_n), .ce(ce), .prod(prod),
    .signed_mode(ctl_d.a_sgn | ctl_d.b_sgn),
    .sub(ctl_d.sub), .load(ctl_d.load),
    .acc_out(acc_out), .ovf(ovf)
  );

  assign a_chain = a_q;
  assign b_chain = b_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int ACC_W = 52
) (
  input logic             clk,
  input logic             arst_n,
  input logic             ce,
  input logic [A_W-1:0]   a_in,
  input logic [B_W-1:0]   b_in,
  input logic [A_W-1:0]   a_chain,
  input logic [B_W-1:0]   b_chain,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf,
  input logic             ld_eff
);
  // R9
  ce_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !ce |=> $stable(acc_out) && $stable(ovf) && $stable(a_chain) && $stable(b_chain));

  // R2
  chain_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ce |=> (a_chain == $past(a_in)) && (b_chain == $past(b_in)));

  // R3
  load_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ce && ld_eff |=> !ovf);

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ovf && !(ce && ld_eff) |=> ovf);
endmodule

bind mac_unit mac_unit_chk #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .ce(ce), .a_in(a_in), .b_in(b_in),
  .a_chain(a_chain), .b_chain(b_chain), .acc_out(acc_out), .ovf(ovf),
  .ld_eff(ld_eff)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
  localparam int AW = 4, BW = 4, GW = 2;
  localparam int ACCW = AW + BW + GW;
  localparam int MOD = 1 << ACCW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [BW-1:0] b_in = '0;
  logic a_signed = 1'b0, b_signed = 1'b0, sub_mode = 1'b0, load = 1'b0;
  logic [ACCW-1:0] acc_out;
  logic ovf;
  logic [AW-1:0] a_chain;
  logic [BW-1:0] b_chain;

  int checks = 0, errors = 0;
  int acc_m = 0, ovf_m = 0;
  logic [11:0] p1 = '0, p2 = '0;
  logic [15:0] lfsr = 16'hACE1;
  string acc_tag, ovf_tag;

  always #5 clk = ~clk;

  mac_unit #(.A_W(AW), .B_W(BW), .GUARD_W(GW), .SIGN_STAGES(1), .CTRL_STAGES(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .a_in(a_in), .b_in(b_in),
    .a_signed(a_signed), .b_signed(b_signed), .sub_mode(sub_mode), .load(load),
    .acc_out(acc_out), .ovf(ovf), .a_chain(a_chain), .b_chain(b_chain)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // op layout: [11]=load [10]=sub [9]=a_signed [8]=b_signed [7:4]=b [3:0]=a
  task automatic apply(input logic [11:0] op);
    int av, bv, p, accv, t, lim_ovf;
    av = int'(op[3:0]);
    bv = int'(op[7:4]);
    if (op[9] && av >= 8) av -= 16;
    if (op[8] && bv >= 8) bv -= 16;
    p = av * bv;
    if (op[11]) begin
      acc_m = ((p % MOD) + MOD) % MOD;
      ovf_m = 0;
      acc_tag = "R3 load";
      ovf_tag = "R3 load clears flag";
    end else begin
      accv = acc_m;
      if (op[9] | op[8]) begin
        if (accv >= MOD / 2) accv -= MOD;
        t = op[10] ? accv - p : accv + p;
        lim_ovf = (t < -MOD / 2 || t >= MOD / 2) ? 1 : 0;
        ovf_tag = ovf_m ? "R8 sticky" : "R6 signed overflow";
      end else begin
        t = op[10] ? accv - p : accv + p;
        lim_ovf = (t < 0 || t >= MOD) ? 1 : 0;
        ovf_tag = ovf_m ? "R8 sticky" : "R7 carry/borrow";
      end
      acc_tag = op[10] ? "R5 subtract" : "R4 add";
      acc_m = ((t % MOD) + MOD) % MOD;
      ovf_m = ovf_m | lim_ovf;
    end
  endtask

  task automatic drive(input logic [11:0] op);
    a_in = op[3:0]; b_in = op[7:4];
    b_signed = op[8]; a_signed = op[9]; sub_mode = op[10]; load = op[11];
  endtask

  task automatic step(input logic [11:0] op);
    @(negedge clk);
    apply(p2);
    check(acc_tag, int'(acc_out), acc_m);
    check(ovf_tag, int'(ovf), ovf_m);
    check("R2 chain", int'({b_chain, a_chain}), int'(p1[7:0]));
    p2 = p1;
    p1 = op;
    drive(op);
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic rand_burst(input int n);
    for (int i = 0; i < n; i++) begin
      logic [11:0] op;
      next_rand();
      op = {(lfsr[15:12] == 4'd0), lfsr[10:0]};
      step(op);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ACCW-1:0] acc_hold;
    logic ovf_hold;
    logic [7:0] chain_hold;
    repeat (3) @(negedge clk);
    check("R1 reset acc", int'(acc_out), 0);
    check("R1 reset ovf", int'(ovf), 0);
    check("R1 reset chain", int'({b_chain, a_chain}), 0);
    rst_n = 1'b1;
    ce = 1'b1;
    repeat (3) @(negedge clk);
    acc_tag = "R1 idle"; ovf_tag = "R1 idle";

    // R3: every operand pair, every sign-mode combination, as a load
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 256; v++)
        step({1'b1, 1'b0, s[1:0], v[7:0]});

    // R4 R5 R6 R7 R8: mixed stream
    step(12'h8FF);
    rand_burst(3000);
    for (int i = 0; i < 3; i++) step(12'h000);

    // R9: clock enable low freezes everything
    @(negedge clk);
    ce = 1'b0;
    acc_hold = acc_out; ovf_hold = ovf; chain_hold = {b_chain, a_chain};
    for (int i = 0; i < 6; i++) begin
      next_rand();
      drive({lfsr[11:0]});
      @(negedge clk);
      check("R9 acc hold", int'(acc_out), int'(acc_hold));
      check("R9 ovf hold", int'(ovf), int'(ovf_hold));
      check("R9 chain hold", int'({b_chain, a_chain}), int'(chain_hold));
    end
    drive(12'h000);
    ce = 1'b1;
    rand_burst(400);

    // R1: reset in mid-run
    for (int i = 0; i < 3; i++) step(12'h000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async acc", int'(acc_out), 0);
    check("R1 async ovf", int'(ovf), 0);
    check("R1 async chain", int'({b_chain, a_chain}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    acc_m = 0; ovf_m = 0; p1 = '0; p2 = '0;
    rand_burst(800);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule